// File: doc/BRIEF.md
# Halfband Decimate-by-Two Filter

This block halves the sample rate of a stream of signed samples using a linear-phase halfband FIR in polyphase form. Incoming samples take turns between two delay lines. A phase bit that starts on the even side after reset does the steering. The even line only feeds the single centre tap, whose weight of one half is a plain shift. The odd line feeds the nonzero side taps. Because the impulse response is symmetric, each mirrored pair of odd-line samples is summed first. Each pair sum is then scaled once by its coefficient. The scaling uses signed-digit shift-and-add terms, so the filter contains no multiplier.

Two copies are meant to follow the integrator-comb decimator, one after the other, and each may have a different length. The tap count has the form 4k+3. The k+1 distinct side coefficients are integer constants with COEF_FRAC fractional bits, passed as a parameter list. Entry i of the list is the weight at distance 2i+1 from the centre. The minimal signed-digit form of each constant is derived at elaboration. The block emits one rounded and saturated sample for every two accepted inputs.

Top module: `hb_decim2`

## Requirements
- R1: While rstN is low, and after it is released, outValid is 0 and outData is 0 until the first output is produced.
- R2: For every second accepted sample (inValid high at a rising edge) after reset, the block produces one output. outValid is high for exactly one cycle, two rising edges after the edge that accepted that sample.
- R3: No output is produced until NTAPS+1 samples have been accepted since reset. The first outValid follows the (NTAPS+1)-th accepted sample.
- R4: Let x0 be the newest accepted sample and xt the sample accepted t samples earlier, with c = (NTAPS-1)/2. Each output is sum over t of h(t)·xt, scaled by 2^COEF_FRAC. Here h(c) = 2^(COEF_FRAC-1). For |t-c| = 2i+1, h(t) = COEFS[i]. All other h(t) are 0.
- R5: The accumulated sum is rounded half-up before output. The block adds 2^(S-1) and then shifts arithmetically right by S, where S = COEF_FRAC+IN_W-OUT_W. So +0.5 LSB rounds to 1 and -0.5 LSB rounds to 0.
- R6: A rounded value outside the signed OUT_W range is clamped to the largest or smallest representable value.
- R7: Cycles with inValid low change nothing: the phase, the delay lines and the fill state keep their values. outData keeps its last value whenever outValid is low.
- R8: A reset applied in the middle of a stream returns the phase to even and empties the fill state. The R3 count starts again from zero.
- R9: With the default coefficients (sum of side weights equal to one quarter), a constant input settles to an output equal to that constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | High when inData carries a sample |
| inData | input | IN_W | Signed input sample |
| outValid | output | 1 | One-cycle strobe marking a new output sample |
| outData | output | OUT_W | Signed rounded and saturated output sample |

## Verification
The bench builds two instances side by side on the same stimulus. One has the default 11-tap length with three side weights. The other has 7 taps and two side weights, which is the shorter length a second cascade stage would use. Running both checks that the fill depth, the centre position and the pairing of mirrored samples follow NTAPS rather than a fixed layout. The 11-tap weights include a negative term, so an alternating full-scale pattern drives the sum past both ends of the 16-bit range. With unit impulses on the even phase, the accumulator lands exactly on a half LSB in either sign.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Strobes issued by the sequencer to the datapath in a given cycle.
  typedef struct packed {
    logic loadEven;  // write inData into the centre-tap line
    logic loadOdd;   // write inData into the side-tap line
    logic emit;      // register a new output sample
  } hbStrobes_t;

  // Non-adjacent signed-digit recoding of an integer constant.
  // wantNeg = 0 returns the mask of +1 digits, wantNeg = 1 the mask of -1 digits.
  function automatic logic [63:0] csdDigits(input longint value, input bit wantNeg);
    longint rest;
    logic [63:0] mask;
    rest = value;
    mask = '0;
    for (int b = 0; b < 62; b++) begin
      if ((rest & 64'sd1) != 64'sd0) begin
        if ((rest & 64'sd3) == 64'sd1) begin
          if (!wantNeg) mask[b] = 1'b1;
          rest = rest - 64'sd1;
        end else begin
          if (wantNeg) mask[b] = 1'b1;
          rest = rest + 64'sd1;
        end
      end
      rest = rest >>> 1;
    end
    return mask;
  endfunction

endpackage

// File: rtl/hb_ctrl.sv
module hb_ctrl #(
  parameter int FILL_PAIRS = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output hb_pkg::hbStrobes_t strobes
);
  localparam int CNT_W = $clog2(FILL_PAIRS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FILL_PAIRS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILL_PAIRS - 1);

  logic             phaseOdd;
  logic [CNT_W-1:0] pairCount;
  logic             emitQ;

  always_comb begin
    strobes.loadEven = inValid & ~phaseOdd;
    strobes.loadOdd  = inValid &  phaseOdd;
    strobes.emit     = emitQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseOdd  <= 1'b0;
      pairCount <= '0;
      emitQ     <= 1'b0;
    end else begin
      if (inValid) phaseOdd <= ~phaseOdd;
      if (strobes.loadOdd && (pairCount != FULL)) pairCount <= pairCount + 1'b1;
      emitQ <= strobes.loadOdd && (pairCount >= LAST);
    end
  end

endmodule

// File: rtl/hb_csd_term.sv
module hb_csd_term #(
  parameter int IN_W   = 17,
  parameter int OUT_W  = 37,
  parameter int COEF   = 1,
  parameter int COEF_W = 18
) (
  input  logic signed [IN_W-1:0]  sample,
  output logic signed [OUT_W-1:0] product
);
  localparam logic [63:0] POS_M = hb_pkg::csdDigits(longint'(COEF), 1'b0);
  localparam logic [63:0] NEG_M = hb_pkg::csdDigits(longint'(COEF), 1'b1);

  logic signed [OUT_W-1:0] wide;
  logic signed [OUT_W-1:0] terms [COEF_W];

  assign wide = {{(OUT_W-IN_W){sample[IN_W-1]}}, sample};

  for (genvar b = 0; b < COEF_W; b++) begin : g_digit
    if (POS_M[b]) begin : g_pos
      assign terms[b] = wide <<< b;
    end else if (NEG_M[b]) begin : g_neg
      assign terms[b] = -(wide <<< b);
    end else begin : g_zero
      assign terms[b] = '0;
    end
  end

  always_comb begin
    product = '0;
    for (int b = 0; b < COEF_W; b++) product = product + terms[b];
  end

endmodule

// File: rtl/hb_datapath.sv
module hb_datapath #(
  parameter int IN_W      = 16,
  parameter int OUT_W     = 16,
  parameter int NTAPS     = 11,
  parameter int COEF_FRAC = 16,
  parameter int COEFS [(NTAPS+1)/4] = '{19584, -4064, 864}
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  hb_pkg::hbStrobes_t      strobes,
  input  logic signed [IN_W-1:0]  inData,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outData
);
  localparam int K        = (NTAPS - 3) / 4;
  localparam int NPAIR    = K + 1;
  localparam int ODD_LEN  = 2 * K + 2;
  localparam int EVEN_LEN = K + 1;
  localparam int SUM_W    = IN_W + 1;
  localparam int ACC_W    = IN_W + COEF_FRAC + 3 + $clog2(NPAIR + 1);
  localparam int SHIFT    = COEF_FRAC + IN_W - OUT_W;
  localparam int RND_W    = ACC_W - SHIFT;
  localparam logic signed [ACC_W-1:0] HALF =
    {{(ACC_W-1){1'b0}}, 1'b1} << (SHIFT - 1);
  localparam logic signed [RND_W-1:0] MAXV =
    {{(RND_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [RND_W-1:0] MINV =
    {{(RND_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [IN_W-1:0]  evenLine [EVEN_LEN];
  logic signed [IN_W-1:0]  oddLine  [ODD_LEN];
  logic signed [SUM_W-1:0] pairSum  [NPAIR];
  logic signed [ACC_W-1:0] prod     [NPAIR];
  logic signed [ACC_W-1:0] centreTerm;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] accRnd;
  logic signed [RND_W-1:0] scaled;
  logic signed [OUT_W-1:0] satVal;

  // Delay lines: index 0 holds the newest sample of that phase.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < EVEN_LEN; i++) evenLine[i] <= '0;
    end else if (strobes.loadEven) begin
      evenLine[0] <= inData;
      for (int i = 1; i < EVEN_LEN; i++) evenLine[i] <= evenLine[i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ODD_LEN; i++) oddLine[i] <= '0;
    end else if (strobes.loadOdd) begin
      oddLine[0] <= inData;
      for (int i = 1; i < ODD_LEN; i++) oddLine[i] <= oddLine[i-1];
    end
  end

  // Mirrored side taps share one scaling: pair i sits 2i+1 from the centre.
  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    assign pairSum[i] = {oddLine[K-i][IN_W-1], oddLine[K-i]}
                      + {oddLine[K+1+i][IN_W-1], oddLine[K+1+i]};
    hb_csd_term #(
      .IN_W  (SUM_W),
      .OUT_W (ACC_W),
      .COEF  (COEFS[i]),
      .COEF_W(COEF_FRAC + 2)
    ) u_term (
      .sample (pairSum[i]),
      .product(prod[i])
    );
  end

  // Centre weight of one half: a single shift at accumulator scale.
  assign centreTerm = {{(ACC_W-IN_W){evenLine[K][IN_W-1]}}, evenLine[K]} <<< (COEF_FRAC - 1);

  always_comb begin
    acc = centreTerm;
    for (int i = 0; i < NPAIR; i++) acc = acc + prod[i];
  end

  assign accRnd = acc + HALF;
  assign scaled = accRnd[ACC_W-1:SHIFT];

  always_comb begin
    if (scaled > MAXV)      satVal = MAXV[OUT_W-1:0];
    else if (scaled < MINV) satVal = MINV[OUT_W-1:0];
    else                    satVal = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strobes.emit;
      if (strobes.emit) outData <= satVal;
    end
  end

endmodule

// File: rtl/hb_decim2.sv
module hb_decim2 #(
  parameter int IN_W      = 16,
  parameter int OUT_W     = 16,
  parameter int NTAPS     = 11,
  parameter int COEF_FRAC = 16,
  parameter int COEFS [(NTAPS+1)/4] = '{19584, -4064, 864}
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic signed [IN_W-1:0]  inData,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outData
);
  localparam int FILL_PAIRS = (NTAPS + 1) / 2;

  hb_pkg::hbStrobes_t strobes;

  hb_ctrl #(
    .FILL_PAIRS(FILL_PAIRS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .strobes(strobes)
  );

  hb_datapath #(
    .IN_W     (IN_W),
    .OUT_W    (OUT_W),
    .NTAPS    (NTAPS),
    .COEF_FRAC(COEF_FRAC),
    .COEFS    (COEFS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .inData  (inData),
    .outValid(outValid),
    .outData (outData)
  );

endmodule

// File: rtl/hb_decim2_chk.sv
module hb_decim2_chk #(
  parameter int NTAPS = 11,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             outValid,
  input logic [OUT_W-1:0] outData
);
  localparam int CNT_W = $clog2(NTAPS + 2);
  localparam logic [CNT_W-1:0] NEED = CNT_W'(NTAPS + 1);

  logic             phaseQ;
  logic [CNT_W-1:0] acceptCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ    <= 1'b0;
      acceptCnt <= '0;
    end else if (inValid) begin
      phaseQ <= ~phaseQ;
      if (acceptCnt != NEED) acceptCnt <= acceptCnt + 1'b1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |-> (!outValid && outData == '0));

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  p_pair_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid && phaseQ, 2));

  p_fill_depth_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (acceptCnt >= NEED));

  p_hold_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData));

endmodule

bind hb_decim2 hb_decim2_chk #(
  .NTAPS(NTAPS),
  .OUT_W(OUT_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .outValid(outValid),
  .outData (outData)
);

// File: tb/sim_hb_decim2.sv
`timescale 1ns/1ps
module sim_hb_decim2;
  localparam int W  = 16;
  localparam int F  = 16;
  localparam int S  = F;
  localparam int NA = 11;
  localparam int CA [3] = '{19584, -4064, 864};
  localparam int NB = 7;
  localparam int CB [2] = '{18432, -2048};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN;
  logic inValid;
  logic signed [W-1:0] inData;
  logic oVa, oVb;
  logic signed [W-1:0] oDa, oDb;

  hb_decim2 #(.NTAPS(NA), .COEFS(CA)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(oVa), .outData(oDa));

  hb_decim2 #(.NTAPS(NB), .COEFS(CB)) u1 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(oVb), .outData(oDb));

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tag = "R1";

  longint hist[$];
  int nAcc = 0;
  bit aV1, aV2, bV1, bV2;
  longint aD1, aD2, bD1, bD2, lastA, lastB;
  int lfsr = 32'h1ACE5;

  function automatic longint coefAt(bit useA, int i);
    if (useA) return longint'(CA[i]);
    return longint'(CB[i < 2 ? i : 0]);
  endfunction

  function automatic longint refOut(int ntaps, bit useA);
    int k, c, len, d;
    longint acc, h, r;
    k = (ntaps - 3) / 4;
    c = 2 * k + 1;
    len = hist.size();
    acc = 0;
    for (int t = 0; t < ntaps; t++) begin
      d = (t > c) ? t - c : c - t;
      if (d == 0)          h = longint'(1) <<< (F - 1);
      else if (d % 2 == 1) h = coefAt(useA, (d - 1) / 2);
      else                 h = 0;
      acc += h * hist[len - 1 - t];
    end
    r = (acc + (longint'(1) <<< (S - 1))) >>> S;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic int nextRand();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400_0000 : 0);
    return lfsr;
  endfunction

  task automatic cmp(string who, logic gotV, logic signed [W-1:0] gotD,
                     bit expV, longint expD);
    checks++;
    if (gotV !== expV) begin
      errors++;
      $display("FAIL %s %s outValid got %0d expected %0d", tag, who, gotV, expV);
    end
    checks++;
    if (gotD !== W'(expD)) begin
      errors++;
      $display("FAIL %s %s outData got %0d expected %0d", tag, who, gotD, expD);
    end
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic step(bit v, int d);
    inValid = v;
    inData  = W'(d);
    @(posedge clk);
    aV2 = aV1; aD2 = aD1; bV2 = bV1; bD2 = bD1;
    aV1 = 0; bV1 = 0;
    if (v) begin
      hist.push_back(longint'($signed(W'(d))));
      if (hist.size() > 64) void'(hist.pop_front());
      nAcc++;
      if (nAcc % 2 == 0) begin
        if (nAcc >= NA + 1) begin aV1 = 1; aD1 = refOut(NA, 1); end
        if (nAcc >= NB + 1) begin bV1 = 1; bD1 = refOut(NB, 0); end
      end
    end
    if (aV2) lastA = aD2;
    if (bV2) lastB = bD2;
    @(negedge clk);
    cmp("u0", oVa, oDa, aV2, lastA);
    cmp("u1", oVb, oDb, bV2, lastB);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    inValid = 1'b0;
    inData = '0;
    hist.delete();
    for (int i = 0; i < 64; i++) hist.push_back(0);
    nAcc = 0;
    aV1 = 0; aV2 = 0; bV1 = 0; bV2 = 0;
    aD1 = 0; aD2 = 0; bD1 = 0; bD2 = 0; lastA = 0; lastB = 0;
    repeat (3) @(negedge clk);
    tag = "R1";
    cmp("u0", oVa, oDa, 1'b0, 0);
    cmp("u1", oVb, oDb, 1'b0, 0);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    inValid = 1'b0;
    inData = '0;
    @(negedge clk);
    doReset();

    // R1: outputs quiet for a few idle cycles after release
    tag = "R1";
    repeat (4) step(0, 0);

    // R3: fill depth from reset with a ramp
    tag = "R3";
    for (int i = 0; i < 24; i++) step(1, 100 * i - 900);

    // R4: odd-phase impulse walks through the side taps
    tag = "R4";
    for (int i = 0; i < 12; i++) step(1, 0);
    step(1, 0); step(1, 20000);
    for (int i = 0; i < 16; i++) step(1, 0);

    // R5: even-phase unit impulses land on the centre: +1 -> 1, -1 -> 0
    tag = "R5";
    step(1, 1); step(1, 0);
    for (int i = 0; i < 16; i++) step(1, 0);
    step(1, -1); step(1, 0);
    for (int i = 0; i < 16; i++) step(1, 0);

    // R2: back-to-back stream, one pulse per pair
    tag = "R2";
    for (int i = 0; i < 120; i++) step(1, (i * 523) % 30000 - 15000);

    // R4: random full-rate data
    tag = "R4";
    for (int i = 0; i < 300; i++) step(1, nextRand() % 32768);

    // R7: random gaps in the input strobe
    tag = "R7";
    for (int i = 0; i < 300; i++) begin
      int r;
      r = nextRand();
      step((r & 3) != 0, (r >>> 4) % 32768);
    end

    // R6: full-scale pattern matched to the tap signs, both polarities
    tag = "R6";
    for (int j = 0; j < 36; j++) begin
      bit pos;
      pos = (j % 6 != 1) && (j % 6 != 4);
      step(1, 32767);
      step(1, pos ? 32767 : -32768);
    end
    for (int j = 0; j < 36; j++) begin
      bit pos;
      pos = (j % 6 != 1) && (j % 6 != 4);
      step(1, -32768);
      step(1, pos ? -32768 : 32767);
    end

    // R9: constant input settles to the same value
    tag = "R9";
    for (int i = 0; i < 40; i++) step(1, 1000);
    checks++;
    if (oDa !== 16'sd1000) begin
      errors++;
      $display("FAIL R9 u0 settled got %0d expected 1000", oDa);
    end
    checks++;
    if (oDb !== 16'sd1000) begin
      errors++;
      $display("FAIL R9 u1 settled got %0d expected 1000", oDb);
    end

    // R8: reset on an odd count mid-stream, then refill from even phase
    for (int i = 0; i < 5; i++) step(1, 3000 + i);
    @(negedge clk);
    doReset();
    tag = "R8";
    for (int i = 0; i < 40; i++) step(1, 250 * i - 4000);
    for (int i = 0; i < 6; i++) step(0, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule